// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the control sequencer that sits beside a successive-approximation converter. It counts periods of the converter clock and produces three things: a one-cycle sample-and-hold strobe, a busy level for the whole conversion, and a one-cycle done pulse at the end. All conversion lengths are kept in half periods of the converter clock. The counter therefore advances on a half-period tick that the prescaler supplies at twice the converter clock rate. Every other tick is a rising converter-clock edge.

Conversions can be started in three ways. In single mode, software requests each one. In free-running mode, software starts the first one and each completion starts the next. In triggered mode, a hardware trigger starts the conversion; the sequencer then pulses the prescaler reset so that the conversion begins from a known clock phase. A differential channel is sampled on a fixed phase of an internal clock that runs at half the converter rate. Its conversion therefore takes 13 or 14 converter cycles, depending on where that phase clock stands when the conversion starts. Clearing the enable abandons any conversion in progress.

Top module: `adcconv_seq`

## Requirements
- R1: While reset is held, and afterwards until a start is accepted, busy_o, sh_o, done_o and psc_rst_o stay low.
- R2: In single or free-running mode, a start_i pulse is accepted only while busy_o is low. The conversion then begins on the first rising converter edge at or after the request; a rising edge is every second ph_ce_i tick after enable. A start_i pulse while busy_o is high is dropped.
- R3: The first conversion after enable lasts 50 half periods, and sh_o pulses 29 half periods after it begins.
- R4: A later single-ended conversion started by software lasts 26 half periods, with sh_o at 3 half periods.
- R5: In triggered mode (mode_i = 2), an idle trig_i begins a conversion at once. psc_rst_o pulses for exactly one cycle in the following cycle. The conversion lasts 27 half periods with sh_o at 4, counted in ph_ce_i ticks after the trigger.
- R6: A half-rate phase clock is low after enable and flips on every rising converter edge, the start edge included; a triggered start counts as a rising edge. A differential conversion (diff_i = 1) started by software lasts 26 half periods with sh_o at 3 if that clock is low at the start edge, and 28 half periods with sh_o at 5 if it is high.
- R7: In free-running mode (mode_i = 1), done_o and the start of the next conversion fall in the same cycle, and busy_o stays high. The restart takes its length from R4 or R6. Leaving that mode lets the current conversion finish, and none follows.
- R8: done_o and sh_o are single-cycle pulses, they never coincide, and sh_o is only asserted while busy_o is high. Outside free-running mode, busy_o falls in the cycle done_o is high.
- R9: Clearing en_i drops busy_o in the next cycle with no done_o. The next conversion then follows R3.
- R10: trig_i has no effect unless mode_i = 2, and start_i has no effect when mode_i = 2 (mode_i = 3 acts as single mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Sequencer enable; low aborts and rearms the first-conversion length |
| ph_ce_i | input | 1 | Half-period tick from the prescaler |
| start_i | input | 1 | Software start request, one-cycle pulse |
| trig_i | input | 1 | Hardware trigger, one-cycle pulse |
| mode_i | input | 2 | 0 single, 1 free-running, 2 triggered, 3 single |
| diff_i | input | 1 | Selected channel is differential |
| psc_rst_o | output | 1 | One-cycle prescaler reset before a triggered conversion |
| sh_o | output | 1 | Sample-and-hold strobe |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | Conversion complete, one-cycle pulse |

## Verification
In free-running mode, the completion of one conversion and the start of the next land in the same clock cycle. That cycle must show done_o high with busy_o still high. The new conversion's length is fixed by the phase clock as it stood before that edge. The bench runs a chain of free-running differential conversions after a fresh enable to create this collision. At each collision it checks that the restart falls on a rising edge, and it expects the following conversions to take the 28 half-period form. It then leaves free-running mode mid-chain and checks that the last conversion ends with busy_o dropping.

// File: rtl/adcconv_pkg.sv
// Shared types for the conversion sequencer.
package adcconv_pkg;

    // How conversions are launched.
    typedef enum logic [1:0] {
        MD_SINGLE = 2'd0,
        MD_FREE   = 2'd1,
        MD_AUTO   = 2'd2,
        MD_RSVD   = 2'd3
    } run_mode_e;

endpackage

// File: rtl/adcconv_phase.sv
// Tracks the converter clock phase from half-period ticks.
// Assumes: ticks alternate rising/falling; a triggered start is a rising edge.
module adcconv_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic realign_i,
    output logic rise_tick_o,
    output logic ck2_o
);
    logic rise_nxt_q;
    logic ck2_q;

    // Phase flag and half-rate clock, cleared by reset or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            rise_nxt_q <= 1'b1;
            ck2_q      <= 1'b0;
        end else if (realign_i) begin
            rise_nxt_q <= 1'b0;
            ck2_q      <= ~ck2_q;
        end else if (tick_i) begin
            rise_nxt_q <= ~rise_nxt_q;
            if (rise_nxt_q) ck2_q <= ~ck2_q;
        end
    end

    assign rise_tick_o = tick_i & rise_nxt_q;
    assign ck2_o       = ck2_q;
endmodule

// File: rtl/adcconv_launch.sv
// Accepts start requests and triggers and decides when a conversion launches.
// Assumes: start and trigger are single-cycle pulses.
module adcconv_launch
    import adcconv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  run_mode_e mode_i,
    input  logic      start_i,
    input  logic      trig_i,
    input  logic      busy_i,
    input  logic      rise_tick_i,
    output logic      go_user_o,
    output logic      go_auto_o,
    output logic      psc_rst_o
);
    logic pend_q;
    logic psc_q;
    logic user_ok;

    assign user_ok   = (mode_i != MD_AUTO);
    assign go_auto_o = en_i & ~busy_i & ~pend_q & trig_i & (mode_i == MD_AUTO);
    assign go_user_o = en_i & ~busy_i & rise_tick_i & (pend_q | (start_i & user_ok));

    // Pending software request and registered prescaler reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            pend_q <= 1'b0;
            psc_q  <= 1'b0;
        end else begin
            psc_q <= go_auto_o;
            if (go_user_o)                       pend_q <= 1'b0;
            else if (start_i && user_ok && !busy_i) pend_q <= 1'b1;
        end
    end

    assign psc_rst_o = psc_q;
endmodule

// File: rtl/adcconv_timer.sv
// Half-period conversion counter producing sample strobe, busy and done.
// Assumes: all lengths even except the triggered one; free-run restarts land on a rising tick.
module adcconv_timer #(
    parameter int CW        = 6,
    parameter int LEN_FIRST = 50,
    parameter int SH_FIRST  = 29,
    parameter int LEN_SE    = 26,
    parameter int SH_SE     = 3,
    parameter int LEN_AUTO  = 27,
    parameter int SH_AUTO   = 4,
    parameter int LEN_DHI   = 28,
    parameter int SH_DHI    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic go_user_i,
    input  logic go_auto_i,
    input  logic free_i,
    input  logic diff_i,
    input  logic ck2_i,
    output logic busy_o,
    output logic sh_o,
    output logic done_o
);
    logic          busy_q, first_q, sh_q, done_q;
    logic [CW-1:0] cnt_q, len_q, shp_q, nxt;
    logic [CW-1:0] l_len, l_shp, r_len, r_shp;

    // Length and strobe point for a conversion with the given attributes.
    function automatic logic [2*CW-1:0] pick(input logic frst, input logic aut,
                                             input logic dif, input logic hi);
        if (frst)           return {CW'(LEN_FIRST), CW'(SH_FIRST)};
        else if (aut)       return {CW'(LEN_AUTO),  CW'(SH_AUTO)};
        else if (dif && hi) return {CW'(LEN_DHI),   CW'(SH_DHI)};
        else                return {CW'(LEN_SE),    CW'(SH_SE)};
    endfunction

    assign {l_len, l_shp} = pick(first_q, go_auto_i, diff_i, ck2_i);
    assign {r_len, r_shp} = pick(1'b0, 1'b0, diff_i, ck2_i);
    assign nxt            = cnt_q + CW'(1);

    // Conversion state: launch, count, strobe, finish or restart.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            busy_q  <= 1'b0;
            first_q <= 1'b1;
            sh_q    <= 1'b0;
            done_q  <= 1'b0;
            cnt_q   <= '0;
            len_q   <= '0;
            shp_q   <= '0;
        end else begin
            sh_q   <= 1'b0;
            done_q <= 1'b0;
            if (go_user_i || go_auto_i) begin
                busy_q  <= 1'b1;
                first_q <= 1'b0;
                cnt_q   <= '0;
                len_q   <= l_len;
                shp_q   <= l_shp;
            end else if (busy_q && tick_i) begin
                cnt_q <= nxt;
                if (nxt == shp_q) sh_q <= 1'b1;
                if (nxt == len_q) begin
                    done_q <= 1'b1;
                    if (free_i) begin
                        cnt_q <= '0;
                        len_q <= r_len;
                        shp_q <= r_shp;
                    end else begin
                        busy_q <= 1'b0;
                    end
                end
            end
        end
    end

    assign busy_o = busy_q;
    assign sh_o   = sh_q;
    assign done_o = done_q;
endmodule

// File: rtl/adcconv_seq.sv
// Top of the conversion sequencer: phase tracking, launch control, timer.
// Assumes: ph_ce_i is a one-cycle tick at twice the converter clock rate.
module adcconv_seq #(
    parameter int LEN_FIRST = 50,
    parameter int SH_FIRST  = 29,
    parameter int LEN_SE    = 26,
    parameter int SH_SE     = 3,
    parameter int LEN_AUTO  = 27,
    parameter int SH_AUTO   = 4,
    parameter int LEN_DHI   = 28,
    parameter int SH_DHI    = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       ph_ce_i,
    input  logic       start_i,
    input  logic       trig_i,
    input  logic [1:0] mode_i,
    input  logic       diff_i,
    output logic       psc_rst_o,
    output logic       sh_o,
    output logic       busy_o,
    output logic       done_o
);
    import adcconv_pkg::*;

    localparam int CW = $clog2(LEN_FIRST + 1);

    run_mode_e mode;
    logic tick, rise_tick, ck2, go_user, go_auto, psc_rst, busy;

    assign mode = run_mode_e'(mode_i);
    assign tick = ph_ce_i & ~psc_rst;

    adcconv_phase u_phase (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(tick),
        .realign_i(go_auto), .rise_tick_o(rise_tick), .ck2_o(ck2)
    );

    adcconv_launch u_launch (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .mode_i(mode),
        .start_i(start_i), .trig_i(trig_i), .busy_i(busy),
        .rise_tick_i(rise_tick), .go_user_o(go_user), .go_auto_o(go_auto),
        .psc_rst_o(psc_rst)
    );

    adcconv_timer #(
        .CW(CW), .LEN_FIRST(LEN_FIRST), .SH_FIRST(SH_FIRST),
        .LEN_SE(LEN_SE), .SH_SE(SH_SE), .LEN_AUTO(LEN_AUTO), .SH_AUTO(SH_AUTO),
        .LEN_DHI(LEN_DHI), .SH_DHI(SH_DHI)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(tick),
        .go_user_i(go_user), .go_auto_i(go_auto), .free_i(mode == MD_FREE),
        .diff_i(diff_i), .ck2_i(ck2), .busy_o(busy), .sh_o(sh_o), .done_o(done_o)
    );

    assign busy_o    = busy;
    assign psc_rst_o = psc_rst;
endmodule

// File: rtl/adcconv_seq_chk.sv
// Protocol checks on the sequencer ports, attached by bind.
module adcconv_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic ph_ce_i,
    input logic psc_rst_o,
    input logic sh_o,
    input logic busy_o,
    input logic done_o
);
    // R8
    sh_done_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(sh_o && done_o));

    // R8
    sh_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_o |-> busy_o);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R2
    start_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (psc_rst_o || $past(ph_ce_i)));

    // R5
    psc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        psc_rst_o |=> !psc_rst_o);

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!busy_o && !done_o && !sh_o));

    // R8
    end_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && $past(en_i)) |-> done_o);
endmodule

bind adcconv_seq adcconv_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .ph_ce_i(ph_ce_i),
    .psc_rst_o(psc_rst_o), .sh_o(sh_o), .busy_o(busy_o), .done_o(done_o)
);

// File: tb/adcconv_seq_tb_top.sv
module adcconv_seq_tb_top;
    localparam int DIV = 3;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n, en, start, trig, diff;
    logic [1:0] mode;
    logic ph_ce, psc_rst, sh, busy, done;
    logic [1:0] d;

    // Prescaler model: one half-period tick every DIV cycles, restarted by psc_rst.
    always_ff @(posedge clk) begin
        if (!rst_n || psc_rst)  d <= '0;
        else if (d == 2'(DIV-1)) d <= '0;
        else                    d <= d + 2'd1;
    end
    assign ph_ce = (d == 2'(DIV-1)) && !psc_rst;

    adcconv_seq dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .ph_ce_i(ph_ce), .start_i(start),
        .trig_i(trig), .mode_i(mode), .diff_i(diff), .psc_rst_o(psc_rst),
        .sh_o(sh), .busy_o(busy), .done_o(done)
    );

    typedef enum int {K_FIRST, K_SE, K_AUTO, K_DIFF} kind_e;
    typedef struct {kind_e k; bit abort;} item_t;

    item_t exp_q[$];
    item_t cur;
    int total = 0, bad = 0, n_done = 0, ticks = 0, e_len = 0, e_sh = 0;
    bit active = 0, seen13 = 0, seen14 = 0;
    bit ck2_b, rise_b, busy_q, done_q, ph_q, en_q, c2p, rp, auto_st;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic string tag(kind_e k);
        case (k)
            K_FIRST: return "R3";
            K_SE:    return "R4";
            K_AUTO:  return "R5";
            default: return "R6";
        endcase
    endfunction

    // Pop the next expected conversion and fix its length from the phase model.
    task automatic take_next(bit c2);
        if (exp_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected conversion start", 1, 0);
            cur = '{K_SE, 1'b0};
        end else begin
            cur = exp_q.pop_front();
        end
        case (cur.k)
            K_FIRST: begin e_len = 50; e_sh = 29; end
            K_SE:    begin e_len = 26; e_sh = 3;  end
            K_AUTO:  begin e_len = 27; e_sh = 4;  end
            default: begin
                if (c2) begin e_len = 28; e_sh = 5; seen14 = 1; end
                else    begin e_len = 26; e_sh = 3; seen13 = 1; end
            end
        endcase
        ticks = 0;
        active = 1;
    endtask

    // Monitor: tracks the phase clock per R6 and scores each conversion.
    always @(negedge clk) begin
        if (!rst_n) begin
            ck2_b = 0; rise_b = 1; busy_q = 0; done_q = 0; ph_q = 0; en_q = 0; active = 0;
        end else begin
            c2p = ck2_b; rp = rise_b;
            auto_st = busy && !busy_q && psc_rst;
            if (!en_q) begin ck2_b = 0; rise_b = 1; end
            else if (auto_st) begin ck2_b = ~c2p; rise_b = 0; end
            else if (ph_q) begin
                if (rise_b) ck2_b = ~ck2_b;
                rise_b = ~rise_b;
            end
            if (active && ph_q) ticks++;
            if (sh) chk(active && ticks == e_sh && !done, tag(cur.k), "sample point", ticks, e_sh);
            if (done) begin
                chk(active && !cur.abort && ticks == e_len, tag(cur.k), "conversion length", ticks, e_len);
                chk(!done_q, "R8", "done width", 2, 1);
                n_done++;
                if (busy) begin
                    chk(rp, "R7", "restart on rising edge", rp, 1);
                    take_next(c2p);
                end else begin
                    active = 0;
                end
            end else if (busy && !busy_q) begin
                if (!auto_st) chk(ph_q && rp, "R2", "start on rising edge", ph_q && rp, 1);
                take_next(c2p);
            end else if (!busy && busy_q) begin
                chk(cur.abort && !en_q, "R9", "busy dropped without done", 0, 1);
                active = 0;
            end
            busy_q = busy; done_q = done; ph_q = ph_ce; en_q = en;
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic pulse_start();
        start = 1; step(); start = 0;
    endtask

    task automatic pulse_trig();
        trig = 1; step(); trig = 0;
    endtask

    task automatic wait_done(int n);
        while (n_done < n) @(negedge clk);
        step();
    endtask

    task automatic diff_start(bit want);
        forever begin
            @(negedge clk); #1;
            if (ck2_b == want && !busy) break;
        end
        start = 1;
        @(posedge clk); #2;
        start = 0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        rst_n = 0; en = 0; start = 0; trig = 0; mode = 2'd0; diff = 0;
        repeat (3) step();
        @(negedge clk);
        chk(!busy && !done && !sh && !psc_rst, "R1", "outputs in reset", busy, 0);
        step();
        rst_n = 1; en = 1;
        repeat (6) step();
        @(negedge clk);
        chk(!busy && !done && !sh && !psc_rst, "R1", "outputs idle after reset", busy, 0);

        // R3 first conversion; a start while busy is dropped (R2).
        exp_q.push_back('{K_FIRST, 1'b0});
        step(); pulse_start();
        repeat (20) step();
        pulse_start();
        wait_done(1);
        repeat (30) step();
        chk(!busy, "R2", "start while busy ignored", busy, 0);

        // R4 normal single-ended conversion.
        exp_q.push_back('{K_SE, 1'b0});
        pulse_start();
        wait_done(2);

        // R5 triggered conversion with prescaler reset.
        mode = 2'd2; step();
        exp_q.push_back('{K_AUTO, 1'b0});
        pulse_trig();
        @(negedge clk);
        chk(busy && psc_rst, "R5", "busy and prescaler reset after trigger", psc_rst, 1);
        @(negedge clk);
        chk(!psc_rst, "R5", "prescaler reset is one cycle", psc_rst, 0);
        wait_done(3);
        pulse_start();
        repeat (30) step();
        chk(!busy, "R10", "start ignored in triggered mode", busy, 0);
        exp_q.push_back('{K_AUTO, 1'b0});
        pulse_trig();
        wait_done(4);

        // R10 trigger ignored in single mode.
        mode = 2'd0; step();
        pulse_trig();
        repeat (30) step();
        chk(!busy, "R10", "trigger ignored in single mode", busy, 0);

        // R6 differential starts in both phase-clock states.
        diff = 1;
        exp_q.push_back('{K_DIFF, 1'b0});
        diff_start(1'b0);
        wait_done(5);
        exp_q.push_back('{K_DIFF, 1'b0});
        diff_start(1'b1);
        wait_done(6);

        // R7 free-running differential chain after a fresh enable.
        en = 0; step(); en = 1; mode = 2'd1; step();
        exp_q.push_back('{K_FIRST, 1'b0});
        exp_q.push_back('{K_DIFF, 1'b0});
        exp_q.push_back('{K_DIFF, 1'b0});
        exp_q.push_back('{K_DIFF, 1'b0});
        seen14 = 0;
        pulse_start();
        wait_done(9);
        mode = 2'd0;
        wait_done(10);
        repeat (30) step();
        chk(!busy, "R7", "no restart after leaving free mode", busy, 0);
        chk(seen14, "R7", "free-run restart took 14 cycles", seen14, 1);

        // R9 abort, then the next conversion is a first conversion.
        diff = 0;
        exp_q.push_back('{K_SE, 1'b1});
        pulse_start();
        repeat (60) step();
        en = 0; step();
        @(negedge clk);
        chk(!busy && !done, "R9", "abort clears busy", busy, 0);
        en = 1; step();
        exp_q.push_back('{K_FIRST, 1'b0});
        pulse_start();
        wait_done(11);

        chk(seen13 && seen14, "R6", "both differential lengths observed", seen13 + seen14, 2);
        chk(exp_q.size() == 0, "R7", "all expected conversions seen", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule